// File: doc/BRIEF.md
# Debug Bus Comparator Trigger Unit

This block observes every transfer on a CPU bus and turns a qualified comparator hit into one registered, one-cycle action strobe for an on-chip debugger. There are two reference comparators. The first always looks at the bus address. The second looks at the address or at one byte of data, depending on the trigger mode. A mode selects both the match condition and the action that a hit produces. The condition is equality, A or B, A address together with B data, or an inclusive or exclusive address window. The action is a CPU breakpoint, a data capture for the trace buffer, or a begin or end marker for change-of-flow tracing.

Each comparator can optionally be restricted to reads or to writes. For the address-plus-data mode, the R/W controls of comparator A also choose whether the data byte is taken from the read bus or from the write bus. In the address-only modes, an optional execute-tracking qualifier tags each opcode fetch as hit or miss in a short in-order queue. A breakpoint or trace marker is then issued only when that tagged opcode reaches execute, so a prefetched opcode that is discarded by a pipeline flush never fires. While the background debug port is using the bus, the comparators report no hit. Nothing fires unless the unit is armed.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset, `brk_req`, `cap_strobe`, `trace_begin` and `trace_end` are all 0.
- R2: Every strobe is a single-cycle pulse that appears in the cycle after the bus cycle (or execute cycle) that caused it, and only if `arm` was 1 in that causing cycle.
- R3: At most one of `brk_req`, `cap_strobe`, `trace_begin` and `trace_end` is 1 in any cycle.
- R4: While `bdm_active` is 1, no comparator reports a hit, so a bus cycle in that state produces no strobe.
- R5: `trig_mode` 0 raises `brk_req` when `bus_addr` equals `ref_a`. R/W qualification applies as follows. When `rw_en_a` is 1, the cycle must also have `bus_read` equal to `rw_sel_a`, where 1 means read and 0 means write. When `rw_en_a` is 0, R/W is ignored.
- R6: `trig_mode` 1 raises `brk_req` when the address equals `ref_a` (qualified by `rw_en_a`/`rw_sel_a`) or equals `ref_b` (qualified by `rw_en_b`/`rw_sel_b`).
- R7: `trig_mode` 2 raises `brk_req` when the address equals `ref_a` and the selected data byte equals the low 8 bits of `ref_b`. The byte comes from `bus_wdata` only when `rw_en_a` is 1 and `rw_sel_a` is 0. Otherwise it comes from `bus_rdata`.
- R8: `trig_mode` 3 raises `brk_req` when `ref_a` ≤ `bus_addr` ≤ `ref_b`, with both bounds inclusive, qualified by comparator A's R/W controls.
- R9: `trig_mode` 4 raises `brk_req` when the address is outside the window of R8, qualified by comparator A's R/W controls.
- R10: `trig_mode` 5 pulses `cap_strobe` on a comparator A address hit. `cap_data` then carries the data byte of that cycle, chosen by the same rule as in R7.
- R11: `trig_mode` 6 pulses `trace_begin`, and `trig_mode` 7 pulses `trace_end`, on a comparator A address hit.
- R12: With `track_exec` at 1 in modes 0, 1, 3, 4, 6 and 7, hits are evaluated only on fetch cycles (`bus_fetch` 1). Each fetch is queued as a hit or miss tag. The action fires in the cycle after an `exec_valid` pops a hit tag. A plain fetch never fires on its own, and `pipe_flush` discards every queued tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Enables strobe generation |
| trig_mode | input | 3 | Trigger mode 0..7 (see R5-R11) |
| track_exec | input | 1 | Enables execute tracking (R12) |
| ref_a | input | 16 | Comparator A reference / lower bound |
| ref_b | input | 16 | Comparator B reference / upper bound / data byte |
| rw_en_a | input | 1 | Comparator A R/W qualification enable |
| rw_sel_a | input | 1 | Comparator A direction: 1 read, 0 write |
| rw_en_b | input | 1 | Comparator B R/W qualification enable |
| rw_sel_b | input | 1 | Comparator B direction: 1 read, 0 write |
| bus_valid | input | 1 | A bus transfer is present this cycle |
| bus_addr | input | 16 | Transfer address |
| bus_rdata | input | 8 | Read data bus |
| bus_wdata | input | 8 | Write data bus |
| bus_read | input | 1 | 1 read, 0 write |
| bus_fetch | input | 1 | Transfer is an opcode fetch |
| exec_valid | input | 1 | Oldest fetched opcode enters execute |
| pipe_flush | input | 1 | Prefetched opcodes are discarded |
| bdm_active | input | 1 | Background debug port owns the bus |
| brk_req | output | 1 | Breakpoint request pulse |
| cap_strobe | output | 1 | Capture data into trace buffer |
| cap_data | output | 8 | Byte to capture |
| trace_begin | output | 1 | Start change-of-flow trace |
| trace_end | output | 1 | Stop change-of-flow trace |

## Verification
The window tests hit both bounds exactly and one address beyond each. A design with a strict comparison misses an edge, and an inverted outside mode fires inside. The data-bus choice is tested with the reference byte placed on only one of the two buses, so a design that takes the wrong bus, or keys the choice on comparator B, misses a hit or reports a false one. The execution-tracking cases check three things: a matching fetch must stay silent until its execute slot, a second non-matching opcode must not fire, and a flush between fetch and execute must cancel the hit. A design that fires at fetch, misorders the tag queue or ignores the flush fails one of them. Debugger-port cycles and a disarmed unit are driven with matching addresses, where any strobe is a fault.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

   typedef enum logic [2:0] {
      TM_A_EQ     = 3'd0,
      TM_A_OR_B   = 3'd1,
      TM_A_DATA   = 3'd2,
      TM_INSIDE   = 3'd3,
      TM_OUTSIDE  = 3'd4,
      TM_CAPTURE  = 3'd5,
      TM_BEGIN    = 3'd6,
      TM_END      = 3'd7
   } trig_mode_e;

   typedef enum logic [1:0] {
      ACT_BREAK   = 2'd0,
      ACT_CAPTURE = 2'd1,
      ACT_BEGIN   = 2'd2,
      ACT_END     = 2'd3
   } trig_act_e;

   localparam int unsigned NUM_CMP = 2;
   localparam int unsigned CMP_A   = 0;
   localparam int unsigned CMP_B   = 1;

   function automatic logic mode_addr_only(trig_mode_e m);
      return !(m == TM_A_DATA || m == TM_CAPTURE);
   endfunction

   function automatic trig_act_e mode_action(trig_mode_e m);
      case (m)
         TM_CAPTURE: return ACT_CAPTURE;
         TM_BEGIN:   return ACT_BEGIN;
         TM_END:     return ACT_END;
         default:    return ACT_BREAK;
      endcase
   endfunction

endpackage

// File: rtl/dbg_cmp_unit.sv
module dbg_cmp_unit #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] operand,
   input  logic [W-1:0] ref_val,
   input  logic         rw_en,
   input  logic         rw_sel,
   input  logic         bus_read,
   output logic         eq,
   output logic         ge,
   output logic         le,
   output logic         rw_ok
);

   generate
      if (W < 1) begin : g_bad_w
         $error("dbg_cmp_unit: W must be at least 1");
      end
   endgenerate

   always_comb begin
      eq    = (operand == ref_val);
      ge    = (operand >= ref_val);
      le    = (operand <= ref_val);
      rw_ok = !rw_en || (bus_read == rw_sel);
   end

endmodule

// File: rtl/dbg_match_decode.sv
module dbg_match_decode
   import dbg_trig_pkg::*;
(
   input  trig_mode_e mode,
   input  logic       valid,
   input  logic       suppress,
   input  logic       a_eq,
   input  logic       a_ge,
   input  logic       a_rw,
   input  logic       b_eq,
   input  logic       b_le,
   input  logic       b_rw,
   output logic       cond
);

   logic a_hit;
   logic b_hit;
   logic in_window;
   logic raw;

   always_comb begin
      a_hit     = a_eq && a_rw;
      b_hit     = b_eq && b_rw;
      in_window = a_ge && b_le;
      case (mode)
         TM_A_EQ:    raw = a_hit;
         TM_A_OR_B:  raw = a_hit || b_hit;
         TM_A_DATA:  raw = a_hit && b_hit;
         TM_INSIDE:  raw = in_window && a_rw;
         TM_OUTSIDE: raw = !in_window && a_rw;
         default:    raw = a_hit;
      endcase
      cond = valid && !suppress && raw;
   end

endmodule

// File: rtl/dbg_tag_queue.sv
module dbg_tag_queue #(
   parameter int unsigned DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic push,
   input  logic push_tag,
   input  logic pop,
   output logic head_valid,
   output logic head_tag
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1 || DEPTH > 64) begin : g_bad_depth
         $error("dbg_tag_queue: DEPTH must be in 1..64");
      end
   endgenerate

   logic [DEPTH-1:0] tags_q, tags_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      tags_d = tags_q;
      cnt_d  = cnt_q;
      if (pop && cnt_q != '0) begin
         tags_d = tags_q >> 1;
         cnt_d  = cnt_q - 1'b1;
      end
      if (push && cnt_d < CNT_W'(DEPTH)) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) == cnt_d) tags_d[i] = push_tag;
         end
         cnt_d = cnt_d + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tags_q <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         tags_q <= '0;
         cnt_q  <= '0;
      end else begin
         tags_q <= tags_d;
         cnt_q  <= cnt_d;
      end
   end

   assign head_valid = (cnt_q != '0);
   assign head_tag   = tags_q[0];

   // R12: a flush leaves no pending tag behind
   a_r12_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flush) |-> !head_valid);

   // R12: a lone push into a non-full queue grows it by one
   a_r12_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
      $past(push && !pop && !flush && cnt_q < CNT_W'(DEPTH)) |-> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
   import dbg_trig_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned TAG_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [2:0]        trig_mode,
   input  logic              track_exec,
   input  logic [ADDR_W-1:0] ref_a,
   input  logic [ADDR_W-1:0] ref_b,
   input  logic              rw_en_a,
   input  logic              rw_sel_a,
   input  logic              rw_en_b,
   input  logic              rw_sel_b,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_read,
   input  logic              bus_fetch,
   input  logic              exec_valid,
   input  logic              pipe_flush,
   input  logic              bdm_active,
   output logic              brk_req,
   output logic              cap_strobe,
   output logic [DATA_W-1:0] cap_data,
   output logic              trace_begin,
   output logic              trace_end
);

   localparam int unsigned PAD_W = ADDR_W - DATA_W;

   generate
      if (DATA_W < 1 || DATA_W > ADDR_W) begin : g_bad_widths
         $error("dbg_trig_unit: DATA_W must be in 1..ADDR_W");
      end
   endgenerate

   trig_mode_e  mode;
   trig_act_e   act;
   logic        track_active;
   logic        data_mode;
   logic        use_wdata;
   logic [DATA_W-1:0] data_sel;
   logic [ADDR_W-1:0] data_ext;
   logic [ADDR_W-1:0] ref_b_data;

   assign mode         = trig_mode_e'(trig_mode);
   assign act          = mode_action(mode);
   assign track_active = track_exec && mode_addr_only(mode);
   assign data_mode    = (mode == TM_A_DATA);
   assign use_wdata    = rw_en_a && !rw_sel_a;
   assign data_sel     = use_wdata ? bus_wdata : bus_rdata;

   generate
      if (PAD_W == 0) begin : g_no_pad
         assign data_ext   = data_sel;
         assign ref_b_data = ref_b;
      end else begin : g_pad
         assign data_ext   = {{PAD_W{1'b0}}, data_sel};
         assign ref_b_data = {{PAD_W{1'b0}}, ref_b[DATA_W-1:0]};
      end
   endgenerate

   // comparator bank: A on address, B on address or data byte
   logic [NUM_CMP-1:0][ADDR_W-1:0] c_operand, c_ref;
   logic [NUM_CMP-1:0]             c_rw_en, c_rw_sel;
   logic [NUM_CMP-1:0]             c_eq, c_ge, c_le, c_rw_ok;

   assign c_operand[CMP_A] = bus_addr;
   assign c_ref[CMP_A]     = ref_a;
   assign c_rw_en[CMP_A]   = rw_en_a;
   assign c_rw_sel[CMP_A]  = rw_sel_a;
   assign c_operand[CMP_B] = data_mode ? data_ext : bus_addr;
   assign c_ref[CMP_B]     = data_mode ? ref_b_data : ref_b;
   assign c_rw_en[CMP_B]   = rw_en_b;
   assign c_rw_sel[CMP_B]  = rw_sel_b;

   generate
      for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
         dbg_cmp_unit #(.W(ADDR_W)) u_cmp (
            .operand  (c_operand[k]),
            .ref_val  (c_ref[k]),
            .rw_en    (c_rw_en[k]),
            .rw_sel   (c_rw_sel[k]),
            .bus_read (bus_read),
            .eq       (c_eq[k]),
            .ge       (c_ge[k]),
            .le       (c_le[k]),
            .rw_ok    (c_rw_ok[k])
         );
      end
   endgenerate

   logic cond_now;

   dbg_match_decode u_dec (
      .mode     (mode),
      .valid    (bus_valid && (!track_active || bus_fetch)),
      .suppress (bdm_active),
      .a_eq     (c_eq[CMP_A]),
      .a_ge     (c_ge[CMP_A]),
      .a_rw     (c_rw_ok[CMP_A]),
      .b_eq     (c_eq[CMP_B]),
      .b_le     (c_le[CMP_B]),
      .b_rw     (c_rw_ok[CMP_B]),
      .cond     (cond_now)
   );

   // execute tracking
   logic q_push, q_pop, q_flush, q_head_valid, q_head_tag;

   assign q_push  = arm && track_active && bus_valid && bus_fetch;
   assign q_pop   = arm && track_active && exec_valid;
   assign q_flush = pipe_flush || !arm || !track_active;

   dbg_tag_queue #(.DEPTH(TAG_DEPTH)) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (q_flush),
      .push       (q_push),
      .push_tag   (cond_now),
      .pop        (q_pop),
      .head_valid (q_head_valid),
      .head_tag   (q_head_tag)
   );

   logic hit;
   assign hit = arm && (track_active ? (q_pop && q_head_valid && q_head_tag) : cond_now);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_req     <= 1'b0;
         cap_strobe  <= 1'b0;
         cap_data    <= '0;
         trace_begin <= 1'b0;
         trace_end   <= 1'b0;
      end else begin
         brk_req     <= hit && (act == ACT_BREAK);
         cap_strobe  <= hit && (act == ACT_CAPTURE);
         trace_begin <= hit && (act == ACT_BEGIN);
         trace_end   <= hit && (act == ACT_END);
         if (hit && act == ACT_CAPTURE) cap_data <= data_sel;
      end
   end

   // R2: nothing comes out of a cycle in which the unit was disarmed
   a_r2_idle_when_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(arm) |-> !(brk_req || cap_strobe || trace_begin || trace_end));

   // R3: actions are mutually exclusive
   a_r3_single_action: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({brk_req, cap_strobe, trace_begin, trace_end}));

   // R4: debugger port cycles never trigger a direct match
   a_r4_bdm_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bdm_active && !track_active) |-> !(brk_req || cap_strobe || trace_begin || trace_end));

   // R12: in tracking mode a strobe always follows an execute slot
   a_r12_fire_on_exec: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(track_active) && (brk_req || trace_begin || trace_end)) |-> $past(exec_valid));

endmodule

// File: tb/dbg_trig_unit_bench.sv
module dbg_trig_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm, track_exec, rw_en_a, rw_sel_a, rw_en_b, rw_sel_b;
   logic [2:0]  trig_mode;
   logic [15:0] ref_a, ref_b, bus_addr;
   logic [7:0]  bus_rdata, bus_wdata, cap_data;
   logic        bus_valid, bus_read, bus_fetch, exec_valid, pipe_flush, bdm_active;
   logic        brk_req, cap_strobe, trace_begin, trace_end;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #5 clk = ~clk;

   dbg_trig_unit u_dbg_trig_unit (
      .clk, .rst_n, .arm, .trig_mode, .track_exec, .ref_a, .ref_b,
      .rw_en_a, .rw_sel_a, .rw_en_b, .rw_sel_b, .bus_valid, .bus_addr,
      .bus_rdata, .bus_wdata, .bus_read, .bus_fetch, .exec_valid,
      .pipe_flush, .bdm_active, .brk_req, .cap_strobe, .cap_data,
      .trace_begin, .trace_end
   );

   typedef struct {
      string      req;
      logic [3:0] strobes;   // {brk, cap, begin, end}
      logic [7:0] dat;
   } exp_t;

   exp_t sb[$];

   // monitor: compares each result against the scoreboard
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t e;
         logic [3:0] got;
         e   = sb.pop_front();
         got = {brk_req, cap_strobe, trace_begin, trace_end};
         n_tests++;
         if (got !== e.strobes) begin
            n_fail++;
            $display("FAIL %s strobes actual=%b expected=%b", e.req, got, e.strobes);
         end else if (e.strobes[2] && cap_data !== e.dat) begin
            n_fail++;
            $display("FAIL %s cap_data actual=%h expected=%h", e.req, cap_data, e.dat);
         end
      end
   end

   task automatic cyc(string req, logic [3:0] strobes, logic [7:0] dat = 8'h00);
      exp_t e;
      e.req = req; e.strobes = strobes; e.dat = dat;
      sb.push_back(e);
      @(negedge clk);
   endtask

   task automatic quiet();
      bus_valid = 0; bus_fetch = 0; exec_valid = 0; pipe_flush = 0; bdm_active = 0;
      bus_read = 1; bus_rdata = 8'h00; bus_wdata = 8'h00; bus_addr = 16'h0000;
   endtask

   task automatic rd(logic [15:0] a, logic [7:0] d = 8'h00);
      quiet(); bus_valid = 1; bus_read = 1; bus_addr = a; bus_rdata = d;
   endtask

   task automatic wr(logic [15:0] a, logic [7:0] d);
      quiet(); bus_valid = 1; bus_read = 0; bus_addr = a; bus_wdata = d;
   endtask

   localparam logic [3:0] NONE = 4'b0000, BRK = 4'b1000, CAP = 4'b0100,
                          BEG = 4'b0010, ENDT = 4'b0001;

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      arm = 1; trig_mode = 3'd0; track_exec = 0; ref_a = 16'h1234; ref_b = 16'h2000;
      rw_en_a = 0; rw_sel_a = 1; rw_en_b = 0; rw_sel_b = 1;
      quiet();
      repeat (3) @(negedge clk);
      // R1: reset state
      n_tests++;
      if ({brk_req, cap_strobe, trace_begin, trace_end} !== 4'b0000) begin
         n_fail++;
         $display("FAIL R1 reset actual=%b expected=0000", {brk_req, cap_strobe, trace_begin, trace_end});
      end
      rst_n = 1;
      @(negedge clk);

      // R5: equality, R/W ignored then qualified
      rd(16'h1234); cyc("R5 eq read", BRK);
      rd(16'h1235); cyc("R5 miss", NONE);
      wr(16'h1234, 8'h11); cyc("R5 eq write rw ignored", BRK);
      rw_en_a = 1; rw_sel_a = 0;
      rd(16'h1234); cyc("R5 read blocked by write qual", NONE);
      wr(16'h1234, 8'h11); cyc("R5 write qualified", BRK);
      rw_en_a = 0; rw_sel_a = 1;

      // R2: disarmed, R4: debug port cycle
      arm = 0; rd(16'h1234); cyc("R2 disarmed", NONE);
      arm = 1; rd(16'h1234); bdm_active = 1; cyc("R4 bdm suppress", NONE);
      rd(16'h1234); cyc("R2 rearmed single pulse", BRK);
      quiet(); cyc("R2 pulse ends", NONE);

      // R6: A or B
      trig_mode = 3'd1;
      rd(16'h2000); cyc("R6 B hit", BRK);
      rd(16'h1234); cyc("R6 A hit", BRK);
      rd(16'h3000); cyc("R6 miss", NONE);

      // R7: address plus data byte
      trig_mode = 3'd2; ref_b = 16'hFFA5;
      rd(16'h1234, 8'hA5); bus_wdata = 8'h00; cyc("R7 read bus match", BRK);
      rd(16'h1234, 8'h00); bus_wdata = 8'hA5; cyc("R7 write bus ignored", NONE);
      rw_en_a = 1; rw_sel_a = 0;
      wr(16'h1234, 8'hA5); bus_rdata = 8'h00; cyc("R7 write bus match", BRK);
      wr(16'h1234, 8'h00); bus_rdata = 8'hA5; cyc("R7 read bus ignored", NONE);
      rw_en_a = 0; rw_sel_a = 1;

      // R8 / R9: window bounds
      ref_a = 16'h1000; ref_b = 16'h1FFF;
      trig_mode = 3'd3;
      rd(16'h1000); cyc("R8 low bound", BRK);
      rd(16'h1FFF); cyc("R8 high bound", BRK);
      rd(16'h0FFF); cyc("R8 below", NONE);
      rd(16'h2000); cyc("R8 above", NONE);
      trig_mode = 3'd4;
      rd(16'h1000); cyc("R9 low bound", NONE);
      rd(16'h1FFF); cyc("R9 high bound", NONE);
      rd(16'h0FFF); cyc("R9 below", BRK);
      rd(16'h2000); cyc("R9 above", BRK);

      // R10: capture
      trig_mode = 3'd5; ref_a = 16'h1234;
      rd(16'h1234, 8'h5A); cyc("R10 capture read", CAP, 8'h5A);
      rd(16'h1230, 8'h77); cyc("R10 miss", NONE);
      rw_en_a = 1; rw_sel_a = 0;
      wr(16'h1234, 8'h3C); bus_rdata = 8'hEE; cyc("R10 capture write bus", CAP, 8'h3C);
      rw_en_a = 0; rw_sel_a = 1;

      // R11: trace begin / end
      trig_mode = 3'd6; rd(16'h1234); cyc("R11 begin", BEG);
      trig_mode = 3'd7; rd(16'h1234); cyc("R11 end", ENDT);
      rd(16'h4444); cyc("R11 end miss", NONE);

      // R12: execute tracking
      trig_mode = 3'd0; track_exec = 1; ref_a = 16'h4000;
      quiet(); cyc("R12 idle", NONE);
      rd(16'h4000); bus_fetch = 1; cyc("R12 fetch alone silent", NONE);
      rd(16'h4001); bus_fetch = 1; cyc("R12 second fetch", NONE);
      quiet(); exec_valid = 1; cyc("R12 hit executes", BRK);
      quiet(); exec_valid = 1; cyc("R12 miss executes", NONE);
      rd(16'h4000); cyc("R12 non-fetch read ignored", NONE);
      quiet(); exec_valid = 1; cyc("R12 nothing queued", NONE);
      rd(16'h4000); bus_fetch = 1; cyc("R12 fetch before flush", NONE);
      quiet(); pipe_flush = 1; cyc("R12 flush", NONE);
      quiet(); exec_valid = 1; cyc("R12 flushed tag gone", NONE);
      trig_mode = 3'd6;
      rd(16'h4000); bus_fetch = 1; cyc("R12 begin fetch", NONE);
      quiet(); exec_valid = 1; cyc("R12 begin on exec", BEG);
      quiet(); cyc("R12 drain", NONE);

      repeat (3) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule